// File: doc/BRIEF.md
# Camera Exposure Sequencer

This block steps a camera through one picture. A trigger press fires a one-cycle start pulse at an external exposure timer. The sequencer then waits for that timer to finish and fires a one-cycle start pulse at the film-transport motor. When the motor reports success, the sequencer returns to idle. When the motor reports a failure, the sequencer locks into a fault state and drives an error flag for a display. The flag stays up until the user presses the trigger once more, which does not take a picture, or until reset is asserted.

The exposure timer answers its start pulse one cycle late. For that reason the sequencer waits two cycles after its start pulse before it looks at the exposure status, so the stale low level is never read as "exposure done". A press counts only if the trigger was seen low since the previous accepted press. A button that is held down therefore starts one picture, or clears one fault, and no more. All three outputs are decoded from the state register alone. The state fits in three bits, and the one unused code returns to idle.

Top module: `shot_sequencer`

## Requirements
- R1: `rst_i` (active high, asynchronous) forces idle with all outputs low. A trigger already high when reset is released is not accepted until it has been sampled low at least once.
- R2: In idle, a rising clock edge that samples `trigger_i` high with the press armed makes `timer_go_o` high for exactly the following cycle.
- R3: `expose_i` is first sampled at the edge that ends the second cycle after the `timer_go_o` cycle. `motor_go_o` goes high in the cycle after the first edge that samples `expose_i` low. It stays low for as long as `expose_i` is sampled high.
- R4: `motor_go_o` is high for exactly one cycle per picture.
- R5: While waiting on the motor, an edge that samples `motor_ready_i` high and `motor_err_i` low returns the sequencer to idle. An armed trigger sampled at the next edge starts a new picture.
- R6: While waiting on the motor, an edge that samples `motor_err_i` high makes `error_o` high from the next cycle. `error_o` then stays high while no armed trigger is sampled.
- R7: When `motor_ready_i` and `motor_err_i` are sampled high together, the error wins and `error_o` rises.
- R8: In the fault state, one armed trigger press drops `error_o` in the next cycle without any `timer_go_o` pulse. Continuing to hold the trigger starts nothing. Reset also clears the fault.
- R9: A trigger held high continuously starts exactly one picture. A new picture needs the trigger to be sampled low first.
- R10: In idle, `motor_ready_i`, `motor_err_i` and `expose_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Asynchronous reset, active high |
| trigger_i | input | 1 | Shutter button level |
| expose_i | input | 1 | Exposure timer busy, high while exposing |
| motor_ready_i | input | 1 | Film transport completed |
| motor_err_i | input | 1 | Film transport failed |
| error_o | output | 1 | Fault indication for the display |
| timer_go_o | output | 1 | One-cycle exposure start pulse |
| motor_go_o | output | 1 | One-cycle transport start pulse |

## Verification
Every result appears one cycle after the edge that samples its cause:
- `timer_go_o` follows the edge that samples the accepted press.
- `motor_go_o` follows the first edge that samples low exposure, which is at least three edges after the timer pulse.
- `error_o` follows the edge that samples the motor failure, and it drops the cycle after the clearing press.

The bench drives its inputs and its emulated timer and motor on the falling edge. A behavioural model steps on each rising edge. All three outputs are compared against the model on every falling edge, half a cycle after the register that drives them has settled. Directed counts of pulses back this up over whole scenarios.

// File: rtl/shot_seq_pkg.sv
package shot_seq_pkg;

    localparam int unsigned SEQ_STATE_W = 3;

    typedef enum logic [SEQ_STATE_W-1:0] {
        SQ_IDLE      = 3'd0,
        SQ_SHOOT     = 3'd1,
        SQ_SETTLE    = 3'd2,
        SQ_EXPOSE    = 3'd3,
        SQ_KICK      = 3'd4,
        SQ_TRANSPORT = 3'd5,
        SQ_FAULT     = 3'd6
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       armed;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{state: SQ_IDLE, armed: 1'b0};

endpackage

// File: rtl/shot_seq_next.sv
module shot_seq_next
    import shot_seq_pkg::*;
(
    input  seq_regs_t cur_i,
    input  logic      trigger_i,
    input  logic      expose_i,
    input  logic      motor_ready_i,
    input  logic      motor_err_i,
    output seq_regs_t nxt_o
);

    logic press_taken;

    always_comb begin
        nxt_o       = cur_i;
        press_taken = 1'b0;
        case (cur_i.state)
            SQ_IDLE: begin
                if (trigger_i && cur_i.armed) begin
                    nxt_o.state = SQ_SHOOT;
                    press_taken = 1'b1;
                end
            end
            SQ_SHOOT:  nxt_o.state = SQ_SETTLE;
            // exposure unit answers one cycle late: skip a cycle
            SQ_SETTLE: nxt_o.state = SQ_EXPOSE;
            SQ_EXPOSE: begin
                if (!expose_i) begin
                    nxt_o.state = SQ_KICK;
                end
            end
            SQ_KICK:   nxt_o.state = SQ_TRANSPORT;
            SQ_TRANSPORT: begin
                if (motor_err_i) begin
                    nxt_o.state = SQ_FAULT;
                end else if (motor_ready_i) begin
                    nxt_o.state = SQ_IDLE;
                end
            end
            SQ_FAULT: begin
                if (trigger_i && cur_i.armed) begin
                    nxt_o.state = SQ_IDLE;
                    press_taken = 1'b1;
                end
            end
            default:   nxt_o.state = SQ_IDLE;
        endcase

        if (!trigger_i) begin
            nxt_o.armed = 1'b1;
        end else if (press_taken) begin
            nxt_o.armed = 1'b0;
        end
    end

endmodule

// File: rtl/shot_seq_outdec.sv
module shot_seq_outdec
    import shot_seq_pkg::*;
(
    input  seq_state_e state_i,
    output logic       error_o,
    output logic       timer_go_o,
    output logic       motor_go_o
);

    always_comb begin
        error_o    = 1'b0;
        timer_go_o = 1'b0;
        motor_go_o = 1'b0;
        case (state_i)
            SQ_SHOOT: timer_go_o = 1'b1;
            SQ_KICK:  motor_go_o = 1'b1;
            SQ_FAULT: error_o    = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/shot_sequencer.sv
module shot_sequencer
    import shot_seq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic trigger_i,
    input  logic expose_i,
    input  logic motor_ready_i,
    input  logic motor_err_i,
    output logic error_o,
    output logic timer_go_o,
    output logic motor_go_o
);

    seq_regs_t  regs_d;
    seq_regs_t  regs_q;
    seq_state_e cur_state;

    assign cur_state = regs_q.state;

    shot_seq_next u_next (
        .cur_i         (regs_q),
        .trigger_i     (trigger_i),
        .expose_i      (expose_i),
        .motor_ready_i (motor_ready_i),
        .motor_err_i   (motor_err_i),
        .nxt_o         (regs_d)
    );

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            regs_q <= SEQ_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    shot_seq_outdec u_outdec (
        .state_i    (cur_state),
        .error_o    (error_o),
        .timer_go_o (timer_go_o),
        .motor_go_o (motor_go_o)
    );

endmodule

// File: rtl/shot_sequencer_chk.sv
module shot_sequencer_chk
    import shot_seq_pkg::*;
(
    input logic       clk_i,
    input logic       rst_i,
    input logic       trigger_i,
    input logic       expose_i,
    input logic       motor_ready_i,
    input logic       motor_err_i,
    input logic       error_o,
    input logic       timer_go_o,
    input logic       motor_go_o,
    input seq_state_e state_q
);

    p_timer_single_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        timer_go_o |=> !timer_go_o);

    p_timer_from_press_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        timer_go_o |-> $past(trigger_i));

    p_kick_after_low_expose_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        motor_go_o |-> $past(!expose_i));

    p_kick_single_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        motor_go_o |=> !motor_go_o);

    p_ready_returns_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == SQ_TRANSPORT && motor_ready_i && !motor_err_i) |=> (state_q == SQ_IDLE));

    p_fault_latch_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == SQ_TRANSPORT && motor_err_i) |=> error_o);

    p_fault_holds_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (error_o && !trigger_i) |=> error_o);

    p_fault_wins_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == SQ_TRANSPORT && motor_err_i && motor_ready_i) |=> error_o);

    p_clear_no_shot_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        error_o |=> !timer_go_o);

    p_idle_ignores_motor_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == SQ_IDLE && !trigger_i) |=> (!error_o && !motor_go_o && !timer_go_o));

endmodule

bind shot_sequencer shot_sequencer_chk u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .trigger_i     (trigger_i),
    .expose_i      (expose_i),
    .motor_ready_i (motor_ready_i),
    .motor_err_i   (motor_err_i),
    .error_o       (error_o),
    .timer_go_o    (timer_go_o),
    .motor_go_o    (motor_go_o),
    .state_q       (cur_state)
);

// File: tb/shot_sequencer_bench.sv
`timescale 1ns/1ps
module shot_sequencer_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 1'b0;
    logic expose = 1'b0;
    logic mv_rdy = 1'b0, mv_err = 1'b0;
    logic sc_rdy = 1'b0, sc_err = 1'b0;
    logic mrdy, merr;
    logic err, tgo, mgo;

    assign mrdy = mv_rdy | sc_rdy;
    assign merr = mv_err | sc_err;

    always #10 clk = ~clk;

    shot_sequencer u_shot_sequencer (
        .clk_i         (clk),
        .rst_i         (rst),
        .trigger_i     (trig),
        .expose_i      (expose),
        .motor_ready_i (mrdy),
        .motor_err_i   (merr),
        .error_o       (err),
        .timer_go_o    (tgo),
        .motor_go_o    (mgo)
    );

    int    vectors = 0;
    int    misses  = 0;
    int    cycles  = 0;
    int    shots   = 0;
    int    kicks   = 0;
    string scen    = "R1";

    // emulated exposure timer and motor
    int ex_len   = 4;
    bit ex_rise  = 0;
    int ex_left  = 0;
    int m_mode   = 0;   // 0 ready, 1 error, 2 both
    int m_delay  = 3;
    int m_cnt    = 0;

    // behavioural model
    localparam int P_IDLE = 0, P_PULSE = 1, P_GAP = 2, P_EXPO = 3,
                   P_MOTOR = 4, P_TRANS = 5, P_BROKEN = 6;
    int m_phase = P_IDLE;
    bit m_armed = 0;
    bit m_used  = 0;

    task automatic chk(string rq, logic got, logic exp, string nm);
        if (got !== exp) begin
            misses++;
            $display("FAIL %s (%s) %s got %b expected %b at %0t", rq, scen, nm, got, exp, $time);
        end
    endtask

    task automatic chk_int(string rq, int got, int exp, string nm);
        vectors++;
        if (got != exp) begin
            misses++;
            $display("FAIL %s (%s) %s got %0d expected %0d at %0t", rq, scen, nm, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_phase = P_IDLE;
            m_armed = 0;
        end else begin
            m_used = 0;
            if (m_phase == P_IDLE) begin
                if (trig && m_armed) begin m_phase = P_PULSE; m_used = 1; end
            end else if (m_phase == P_PULSE) m_phase = P_GAP;
            else if (m_phase == P_GAP) m_phase = P_EXPO;
            else if (m_phase == P_EXPO) begin
                if (!expose) m_phase = P_MOTOR;
            end else if (m_phase == P_MOTOR) m_phase = P_TRANS;
            else if (m_phase == P_TRANS) begin
                if (merr) m_phase = P_BROKEN;
                else if (mrdy) m_phase = P_IDLE;
            end else if (m_phase == P_BROKEN) begin
                if (trig && m_armed) begin m_phase = P_IDLE; m_used = 1; end
            end
            if (!trig) m_armed = 1;
            else if (m_used) m_armed = 0;
        end
    end

    always @(negedge clk) begin
        cycles++;
        vectors++;
        chk("R2", tgo, m_phase == P_PULSE, "timer_go");
        chk("R4", mgo, m_phase == P_MOTOR, "motor_go");
        chk("R6", err, m_phase == P_BROKEN, "error");
        if (tgo) shots++;
        if (mgo) kicks++;
        // exposure timer: busy one cycle after the pulse, for ex_len cycles
        if (ex_rise) begin
            ex_rise = 0;
            if (ex_len > 0) begin expose = 1'b1; ex_left = ex_len; end
        end else if (ex_left > 0) begin
            ex_left--;
            if (ex_left == 0) expose = 1'b0;
        end
        if (tgo) ex_rise = 1;
        // motor: one-cycle answer m_delay cycles after the kick
        mv_rdy = 1'b0;
        mv_err = 1'b0;
        if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                mv_rdy = (m_mode != 1);
                mv_err = (m_mode != 0);
            end
        end
        if (mgo) m_cnt = m_delay;
        if (cycles > 20000) begin
            misses++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press;
        trig = 1'b1; cyc(1); trig = 1'b0;
    endtask

    initial begin
        // R1: reset with trigger held, no start until released
        scen = "R1";
        trig = 1'b1;
        cyc(3);
        rst = 1'b0;
        cyc(5);
        chk_int("R1", shots, 0, "shots after reset with held trigger");
        trig = 1'b0;
        cyc(2);

        // R2 / R4: normal picture
        scen = "R2";
        ex_len = 4; m_mode = 0; m_delay = 3;
        shots = 0; kicks = 0;
        press();
        cyc(20);
        chk_int("R2", shots, 1, "timer pulses");
        chk_int("R4", kicks, 1, "motor pulses");

        // R3: exposure never rises, then a long exposure
        scen = "R3";
        ex_len = 0; shots = 0; kicks = 0;
        press();
        cyc(15);
        chk_int("R3", kicks, 1, "kick with no exposure");
        ex_len = 25; kicks = 0;
        press();
        cyc(20);
        chk_int("R3", kicks, 0, "no kick while exposing");
        cyc(20);
        chk_int("R3", kicks, 1, "kick after long exposure");

        // R9: held trigger gives one picture only
        scen = "R9";
        ex_len = 3; shots = 0;
        trig = 1'b1;
        cyc(60);
        chk_int("R9", shots, 1, "pictures with held trigger");
        trig = 1'b0; cyc(1);
        press();
        cyc(25);
        chk_int("R9", shots, 2, "pictures after release");

        // R5: toggling trigger restarts as soon as idle returns
        scen = "R5";
        m_delay = 1; ex_len = 2; shots = 0;
        for (int i = 0; i < 20; i++) begin
            trig = 1'b1; cyc(1); trig = 1'b0; cyc(1);
        end
        cyc(20);
        chk_int("R5", (shots >= 3) ? 1 : 0, 1, "repeated pictures");

        // R6: motor failure latches error
        scen = "R6";
        m_mode = 1; m_delay = 2; ex_len = 3;
        press();
        cyc(20);
        chk_int("R6", int'(err), 1, "error after motor failure");
        cyc(10);
        chk_int("R6", int'(err), 1, "error still held");

        // R8: trigger clears fault without picture; holding starts nothing
        scen = "R8";
        shots = 0;
        press();
        cyc(3);
        chk_int("R8", int'(err), 0, "error after clearing press");
        chk_int("R8", shots, 0, "pictures from clearing press");
        press();
        cyc(18);
        chk_int("R8", int'(err), 1, "second fault");
        shots = 0;
        trig = 1'b1;
        cyc(12);
        chk_int("R8", int'(err), 0, "fault cleared by held press");
        chk_int("R8", shots, 0, "held clearing press starts nothing");
        trig = 1'b0; cyc(2);
        press();
        cyc(18);
        rst = 1'b1; cyc(1); rst = 1'b0;
        cyc(2);
        chk_int("R8", int'(err), 0, "reset clears fault");

        // R7: ready and error together
        scen = "R7";
        m_mode = 2; m_delay = 2;
        press();
        cyc(20);
        chk_int("R7", int'(err), 1, "error wins over ready");
        press();
        cyc(3);

        // R10: motor and exposure inputs in idle
        scen = "R10";
        kicks = 0; shots = 0;
        sc_rdy = 1'b1; cyc(2); sc_rdy = 1'b0;
        sc_err = 1'b1; cyc(2); sc_err = 1'b0;
        cyc(3);
        chk_int("R10", int'(err), 0, "error after idle motor inputs");
        chk_int("R10", kicks + shots, 0, "pulses after idle motor inputs");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule